// File: doc/BRIEF.md
# SPI Byte Master with Register Interface

This block is a memory-mapped SPI master that exchanges one 8-bit byte at a time in full duplex. Software configures the serial clock rate and the clock mode through a control register, enables master operation through a system-control register, then writes a byte to the transmit buffer. That write starts an exchange. The block asserts its single chip select, shifts the byte out most significant bit first and shifts the slave's reply in at the same time. It then latches the reply into the receive buffer and raises a receive-full flag.

The serial clock comes from the system clock through two stages. The first stage is a coarse prescaler with two settings, `PRE_LO` (default 16) and `PRE_HI` (default 128). The second stage is an even divider of 2×(n+1), where n is five bits wide. Software works by polling. It waits for the busy flag to read 0, writes the transmit buffer, waits for the receive-full flag, and then reads the receive buffer, which clears that flag. To receive without sending data, software writes a dummy byte.

Top module: `spi_byte_master`

## Requirements
- R1: Register map by byte address. 0x00 is the control register (read/write). Its bits are: 7 = clock phase, 6 = clock polarity, 5 = prescale select, 4:0 = divider value n. 0x04 is the status register (bit 0 = busy, bit 2 = receive-full). 0x08 is the system-control register (bit 0 = master enable). 0x0C is the transmit buffer (write-only, reads 0). 0x10 is the receive buffer (bits 7:0). 0x14 and any unused address read 0.
- R2: One byte exchange lasts 16×P×(n+1) system clocks, where P is `PRE_LO` when control bit 5 is 0 and `PRE_HI` when it is 1. The serial clock toggles once every P×(n+1) clocks.
- R3: Data moves most significant bit first in both directions. After an exchange, the receive buffer holds the 8 bits the slave sent, and the slave has received the written byte.
- R4: The serial clock rests at the polarity bit's level while idle. With phase 0, data is sampled on the leading edge of each clock pulse; with phase 1, on the trailing edge. All four modes are supported.
- R5: Status bit 0 reads 1 from the clock edge that accepts a transmit write until the last serial clock edge of that byte, and 0 otherwise.
- R6: Status bit 2 is set when an exchange completes. A read of the receive buffer clears it.
- R7: A write to the status register with bit 2 at 0 clears the receive-full flag. A write with bit 2 at 1 leaves it unchanged.
- R8: A transmit write while system-control bit 0 is 0 starts nothing: the chip select stays high and busy stays 0.
- R9: A transmit write while busy is ignored. The byte in flight and its timing are not disturbed.
- R10: The chip select output is low exactly while an exchange is in progress.
- R11: A control register write during an exchange changes neither the rate nor the mode of that byte. The new setting applies from the next byte.
- R12: After reset, all registers read 0, the chip select is high and the serial clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects only) |
| bus_addr | input | 5 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Chip select, active low |

## Verification
A miscounted edge or divider state shows at the ports within a single byte. The chip select low window becomes longer or shorter than 16×P×(n+1) clocks, or the captured byte comes out rotated or shifted by a bit. An error in the configuration snapshot shows only when the control register is rewritten mid-byte, as a changed window length for that same byte. A flag that fails to clear or set is seen at the next status read after the exchange, a few cycles later.

// File: rtl/spi_byte_master_pkg.sv
package spi_byte_master_pkg;

    localparam int BYTE_W = 8;
    localparam int DIV_W  = 5;
    localparam int EDGE_W = $clog2(2 * BYTE_W);
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] A_CTRL = 5'h00;
    localparam logic [ADDR_W-1:0] A_STAT = 5'h04;
    localparam logic [ADDR_W-1:0] A_SYS  = 5'h08;
    localparam logic [ADDR_W-1:0] A_TX   = 5'h0C;
    localparam logic [ADDR_W-1:0] A_RX   = 5'h10;

    // Field order is the register bit order (7 downto 0).
    typedef struct packed {
        logic             cpha;
        logic             cpol;
        logic             pre_hi;
        logic [DIV_W-1:0] ndiv;
    } spi_cfg_t;

    typedef enum logic {
        SH_IDLE = 1'b0,
        SH_RUN  = 1'b1
    } sh_state_e;

    typedef struct packed {
        sh_state_e         state;
        spi_cfg_t          cfg;
        logic              sclk;
        logic [BYTE_W-1:0] tx_sr;
        logic [BYTE_W-1:0] rx_sr;
        logic [EDGE_W-1:0] edge_n;
    } sh_regs_t;

    typedef struct packed {
        spi_cfg_t          cfg;
        logic              master;
        logic              rx_full;
        logic [BYTE_W-1:0] rx_buf;
    } top_regs_t;

endpackage

// File: rtl/spi_clk_div.sv
module spi_clk_div
    import spi_byte_master_pkg::*;
#(
    parameter int PRE_LO = 16,
    parameter int PRE_HI = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             pre_hi_i,
    input  logic [DIV_W-1:0] ndiv_i,
    output logic             tick_o
);

    localparam int HALF_MAX = PRE_HI * (1 << DIV_W);
    localparam int CW       = $clog2(HALF_MAX + 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] pre_v;
    logic [CW-1:0] half_v;

    always_comb begin
        pre_v  = pre_hi_i ? CW'(PRE_HI) : CW'(PRE_LO);
        half_v = pre_v * (CW'(ndiv_i) + CW'(1));
        tick_o = run_i && (cnt_q == half_v - CW'(1));
        if (!run_i || tick_o) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/spi_shifter.sv
module spi_shifter
    import spi_byte_master_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [BYTE_W-1:0] tx_byte_i,
    input  spi_cfg_t          cfg_i,
    input  logic              idle_cpol_i,
    input  logic              tick_i,
    input  logic              miso_i,
    output spi_cfg_t          cfg_lat_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [BYTE_W-1:0] rx_byte_o,
    output logic              sclk_o,
    output logic              mosi_o,
    output logic              cs_n_o
);

    localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(2 * BYTE_W - 1);

    sh_regs_t r_d, r_q;
    logic     lead;
    logic     samp;

    always_comb begin
        r_d    = r_q;
        done_o = 1'b0;
        lead   = ~r_q.edge_n[0];
        samp   = lead ^ r_q.cfg.cpha;
        unique case (r_q.state)
            SH_IDLE: begin
                r_d.sclk = idle_cpol_i;
                if (start_i) begin
                    r_d.state  = SH_RUN;
                    r_d.cfg    = cfg_i;
                    r_d.sclk   = cfg_i.cpol;
                    r_d.tx_sr  = tx_byte_i;
                    r_d.rx_sr  = '0;
                    r_d.edge_n = '0;
                end
            end
            SH_RUN: begin
                if (tick_i) begin
                    r_d.sclk   = ~r_q.sclk;
                    r_d.edge_n = r_q.edge_n + EDGE_W'(1);
                    if (samp) begin
                        r_d.rx_sr = {r_q.rx_sr[BYTE_W-2:0], miso_i};
                    end else if (!(r_q.cfg.cpha && r_q.edge_n == '0)) begin
                        r_d.tx_sr = {r_q.tx_sr[BYTE_W-2:0], 1'b0};
                    end
                    if (r_q.edge_n == LAST_EDGE) begin
                        r_d.state = SH_IDLE;
                        done_o    = 1'b1;
                    end
                end
            end
            default: r_d = r_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cfg_lat_o = r_q.cfg;
    assign busy_o    = (r_q.state == SH_RUN);
    assign cs_n_o    = (r_q.state != SH_RUN);
    assign rx_byte_o = r_d.rx_sr;
    assign sclk_o    = r_q.sclk;
    assign mosi_o    = r_q.tx_sr[BYTE_W-1];

endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
    import spi_byte_master_pkg::*;
#(
    parameter int PRE_LO = 16,
    parameter int PRE_HI = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              spi_cs_n
);

    top_regs_t         r_d, r_q;
    spi_cfg_t          lat_cfg;
    logic              sh_busy;
    logic              sh_done;
    logic              sh_start;
    logic              div_tick;
    logic [BYTE_W-1:0] sh_rx;
    logic              unused_wdata;

    assign unused_wdata = ^bus_wdata[31:BYTE_W];

    assign sh_start = bus_wr && (bus_addr == A_TX) && r_q.master && !sh_busy;

    always_comb begin
        r_d = r_q;
        if (bus_wr && bus_addr == A_CTRL) begin
            r_d.cfg = spi_cfg_t'(bus_wdata[BYTE_W-1:0]);
        end
        if (bus_wr && bus_addr == A_SYS) begin
            r_d.master = bus_wdata[0];
        end
        if (bus_wr && bus_addr == A_STAT && !bus_wdata[2]) begin
            r_d.rx_full = 1'b0;
        end
        if (bus_rd && bus_addr == A_RX) begin
            r_d.rx_full = 1'b0;
        end
        if (sh_done) begin
            r_d.rx_buf  = sh_rx;
            r_d.rx_full = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        unique case (bus_addr)
            A_CTRL:  bus_rdata = {24'd0, r_q.cfg};
            A_STAT:  bus_rdata = {29'd0, r_q.rx_full, 1'b0, sh_busy};
            A_SYS:   bus_rdata = {31'd0, r_q.master};
            A_RX:    bus_rdata = {24'd0, r_q.rx_buf};
            default: bus_rdata = 32'd0;
        endcase
    end

    spi_clk_div #(
        .PRE_LO (PRE_LO),
        .PRE_HI (PRE_HI)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (sh_busy),
        .pre_hi_i (lat_cfg.pre_hi),
        .ndiv_i   (lat_cfg.ndiv),
        .tick_o   (div_tick)
    );

    spi_shifter u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (sh_start),
        .tx_byte_i   (bus_wdata[BYTE_W-1:0]),
        .cfg_i       (r_q.cfg),
        .idle_cpol_i (r_q.cfg.cpol),
        .tick_i      (div_tick),
        .miso_i      (spi_miso),
        .cfg_lat_o   (lat_cfg),
        .busy_o      (sh_busy),
        .done_o      (sh_done),
        .rx_byte_o   (sh_rx),
        .sclk_o      (spi_sclk),
        .mosi_o      (spi_mosi),
        .cs_n_o      (spi_cs_n)
    );

endmodule

// File: rtl/spi_byte_master_chk.sv
module spi_byte_master_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       spi_cs_n,
    input logic       spi_sclk,
    input logic       busy,
    input logic       done,
    input logic       rx_full,
    input logic       master,
    input logic       ctrl_cpol,
    input logic [7:0] lat_cfg
);

    // R10
    cs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n != busy);

    // R6
    rxfull_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_full) |-> $past(done));

    // R8
    start_needs_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(master));

    // R11
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(lat_cfg));

    // R4
    sclk_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy)) |-> (spi_sclk == $past(ctrl_cpol)));

endmodule

bind spi_byte_master spi_byte_master_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .spi_cs_n  (spi_cs_n),
    .spi_sclk  (spi_sclk),
    .busy      (sh_busy),
    .done      (sh_done),
    .rx_full   (r_q.rx_full),
    .master    (r_q.master),
    .ctrl_cpol (r_q.cfg.cpol),
    .lat_cfg   (lat_cfg)
);

// File: tb/tb_spi_byte_master.sv
module tb_spi_byte_master;

    localparam int PLO = 2;
    localparam int PHI = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        spi_sclk, spi_mosi, spi_miso, spi_cs_n;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // bench-side slave model
    logic       bcpha = 1'b0, bcpol = 1'b0;
    logic [7:0] sl_pat = '0, sl_sr = '0, sl_rx = '0;
    int         sl_edges = 16;

    always #10 clk = ~clk;

    spi_byte_master #(.PRE_LO(PLO), .PRE_HI(PHI)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .spi_cs_n(spi_cs_n)
    );

    assign spi_miso = sl_sr[7];

    always @(negedge spi_cs_n) begin
        sl_sr    = sl_pat;
        sl_edges = 0;
    end

    always @(spi_sclk) begin
        if (sl_edges < 16) begin
            if (((spi_sclk != bcpol) ? 1'b1 : 1'b0) ^ bcpha) begin
                sl_rx = {sl_rx[6:0], spi_mosi};
            end else if (!(bcpha && sl_edges == 0)) begin
                sl_sr = {sl_sr[6:0], 1'b0};
            end
            sl_edges = sl_edges + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        bus_rd   = 1'b1;
        #1;
        d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // one byte exchange; returns chip-select-low cycle count
    task automatic xfer(input logic [7:0] cfg, input logic [7:0] tx,
                        input logic [7:0] pat, output int cyc);
        bcpha  = cfg[7];
        bcpol  = cfg[6];
        sl_pat = pat;
        bus_write(5'h00, {24'd0, cfg});
        bus_write(5'h0C, {24'd0, tx});
        cyc = 0;
        while (!spi_cs_n) begin
            cyc++;
            @(negedge clk);
        end
    endtask

    function automatic int dur(input logic [7:0] cfg);
        return 16 * (cfg[5] ? PHI : PLO) * (int'(cfg[4:0]) + 1);
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        int cyc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        bus_read(5'h00, rd); chk("R12 ctrl", rd, 0);
        bus_read(5'h04, rd); chk("R12 status", rd, 0);
        bus_read(5'h08, rd); chk("R12 sysctl", rd, 0);
        bus_read(5'h10, rd); chk("R12 rxbuf", rd, 0);
        chk("R12 cs_n", spi_cs_n, 1);
        chk("R12 sclk", spi_sclk, 0);

        // R1 register map
        bus_write(5'h00, 32'hFFFF_FFE5);
        bus_read(5'h00, rd); chk("R1 ctrl readback", rd, 32'hE5);
        bus_read(5'h0C, rd); chk("R1 tx reads zero", rd, 0);
        bus_read(5'h14, rd); chk("R1 0x14 reads zero", rd, 0);

        // R8 transfer refused without master mode
        bus_write(5'h0C, 32'h5A);
        repeat (20) @(negedge clk);
        chk("R8 cs_n stays high", spi_cs_n, 1);
        bus_read(5'h04, rd); chk("R8 busy stays 0", rd, 0);

        bus_write(5'h08, 32'h1);
        bus_read(5'h08, rd); chk("R1 sysctl readback", rd, 1);

        // R2 R3 sweep over every divider setting
        for (int p = 0; p < 2; p++) begin
            for (int n = 0; n < 32; n++) begin
                logic [7:0] cfg, tx, pat;
                cfg = {2'b00, 1'(p), 5'(n)};
                tx  = 8'(n * 37 + p * 101 + 3);
                pat = ~tx ^ 8'(n);
                xfer(cfg, tx, pat, cyc);
                chk("R2 byte duration", cyc, dur(cfg));
                chk("R3 slave got tx", sl_rx, tx);
                bus_read(5'h10, rd); chk("R3 rxbuf", rd, {24'd0, pat});
            end
        end

        // R4 all four modes, R5 busy during byte
        for (int m = 0; m < 4; m++) begin
            for (int k = 0; k < 4; k++) begin
                logic [7:0] cfg, tx, pat;
                cfg = {2'(m), 1'b0, 5'd2};
                tx  = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : (k == 2) ? 8'hA5 : 8'h3C;
                tx  = tx ^ 8'(m * 17);
                pat = {tx[3:0], tx[7:4]} ^ 8'h81;
                bus_write(5'h00, {24'd0, cfg});
                @(negedge clk);
                chk("R4 idle sclk level", spi_sclk, cfg[6]);
                xfer(cfg, tx, pat, cyc);
                chk("R4 mode slave got tx", sl_rx, tx);
                chk("R4 rest level after byte", spi_sclk, cfg[6]);
                bus_read(5'h10, rd); chk("R4 mode rxbuf", rd, {24'd0, pat});
            end
        end

        // R5 R10 busy and chip select mid-byte
        bcpha = 0; bcpol = 0; sl_pat = 8'h11;
        bus_write(5'h00, 32'h03);
        bus_write(5'h0C, 32'h22);
        bus_read(5'h04, rd); chk("R5 busy mid-byte", rd[0], 1);
        chk("R10 cs_n low mid-byte", spi_cs_n, 0);
        while (!spi_cs_n) @(negedge clk);
        bus_read(5'h04, rd); chk("R5 R6 status after byte", rd, 32'h4);
        chk("R10 cs_n high after byte", spi_cs_n, 1);

        // R6 cleared by rx read
        bus_read(5'h10, rd); chk("R6 rxbuf", rd, 32'h11);
        bus_read(5'h04, rd); chk("R6 flag cleared by read", rd, 0);

        // R7 status write
        xfer(8'h01, 8'h44, 8'h99, cyc);
        bus_write(5'h04, 32'h4);
        bus_read(5'h04, rd); chk("R7 write bit2=1 keeps flag", rd, 32'h4);
        bus_write(5'h04, 32'h0);
        bus_read(5'h04, rd); chk("R7 write 0 clears flag", rd, 0);
        bus_read(5'h10, rd); chk("R7 rxbuf kept", rd, 32'h99);

        // R9 write while busy ignored
        bcpha = 0; bcpol = 0; sl_pat = 8'h6B;
        bus_write(5'h00, 32'h02);
        bus_write(5'h0C, 32'hC3);
        bus_write(5'h0C, 32'h3C);
        while (!spi_cs_n) @(negedge clk);
        chk("R9 slave got first byte", sl_rx, 8'hC3);
        repeat (10) @(negedge clk);
        chk("R9 no second byte", spi_cs_n, 1);
        bus_read(5'h10, rd); chk("R9 rxbuf", rd, 32'h6B);

        // R11 control change mid-byte
        bcpha = 0; bcpol = 0; sl_pat = 8'hE7;
        bus_write(5'h00, 32'h01);
        bus_write(5'h0C, 32'h18);
        bus_write(5'h00, 32'h1F);
        cyc = 2;
        while (!spi_cs_n) begin
            cyc++;
            @(negedge clk);
        end
        chk("R11 old rate kept", cyc, dur(8'h01));
        chk("R11 old byte intact", sl_rx, 8'h18);
        xfer(8'h03, 8'h81, 8'h7E, cyc);
        chk("R11 new rate next byte", cyc, dur(8'h03));

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule